// File: doc/BRIEF.md
# Receive-Data Interrupt Condition Controller

This block sits beside four 8-bit receive data registers that an upstream serial channel fills. Each register has its own update strobe with a data byte. The block stores each byte and decides, from a 2-bit condition field, whether that update should raise a receive-data interrupt.

The field can turn interrupts off. It can also fire on any update, fire only on updates that carry a nonzero byte, or fire only when the highest-numbered register is written. A qualifying update sets a sticky status flag and sends a one-cycle pulse toward an interrupt controller. Software can also set or clear the flag through write-one strobes; a software set does not pulse the interrupt line.

The register count and data width are parameters; the defaults are four registers of eight bits. The reset input is asynchronous and active-low, and it is released synchronously upstream of the block.

Top module: `rxd_irq_ctrl`

## Requirements
- R1: After reset, the condition field reads 00, the status flag is 0, the interrupt pulse is 0 and every data register reads 0x00.
- R2: When register i's update strobe is high, the register takes the byte on its lane, and the new value shows on `rx_data` one cycle later. Without its strobe, a register holds its value. Register i occupies bits [8i+7:8i] of `upd_data` and `rx_data`.
- R3: `cfg_we` loads `cfg_mode` into the condition field, which shows on `mode_o` one cycle later. An update arriving in the same cycle as the write is judged under the previous condition.
- R4: Condition 00 never produces an interrupt pulse and never sets the flag from hardware.
- R5: Under condition 01, any update of any register produces an interrupt pulse and sets the flag, both visible one cycle after the strobe.
- R6: Under condition 10, an update qualifies only when the byte written in that cycle is nonzero. The value the register held before is irrelevant.
- R7: Under condition 11, only updates of register 3 qualify; updates of registers 0 to 2 produce nothing.
- R8: When several registers update in one cycle, at most one single-cycle pulse results, and it is low in the following idle cycle.
- R9: `sw_set` high sets the flag one cycle later without an interrupt pulse. `sw_clr` high clears it. With both strobes low, the flag holds its value.
- R10: A hardware event in the same cycle as `sw_clr` leaves the flag set. `sw_set` and `sw_clr` together also leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Condition field write strobe |
| cfg_mode | input | 2 | New condition: 00 off, 01 any, 10 nonzero, 11 last register |
| mode_o | output | 2 | Current condition field |
| upd_valid | input | 4 | Per-register update strobes |
| upd_data | input | 32 | Update bytes, lane i at [8i+7:8i] |
| rx_data | output | 32 | Stored register contents, same lane layout |
| sw_set | input | 1 | Write-one set of the status flag |
| sw_clr | input | 1 | Write-one clear of the status flag |
| status_flag | output | 1 | Sticky receive-data status |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions check several relations on every cycle:
- The field load and register load/hold behaviour.
- A pulse always comes with a set flag.
- The off and last-register conditions stay silent when they should.
- The flag is sticky and clears on a lone clear.
- A software set never pulses, and a hardware set beats a clear.

Only the bench's scenarios can show the rest. Its sweep covers every condition against every strobe mask and every zero/nonzero lane pattern. That sweep shows that the nonzero test looks at the incoming byte and that simultaneous updates collapse to one pulse. Directed cases confirm that a condition written in the same cycle as an update does not yet apply.

// File: rtl/rxd_irq_pkg.sv
package rxd_irq_pkg;
  typedef enum logic [1:0] {
    COND_OFF     = 2'b00,
    COND_ANY     = 2'b01,
    COND_NONZERO = 2'b10,
    COND_LAST    = 2'b11
  } cond_e;
endpackage

// File: rtl/rxd_data_bank.sv
module rxd_data_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS-1:0]          upd_valid,
  input  logic [NUM_REGS*DATA_W-1:0]   upd_data,
  output logic [NUM_REGS*DATA_W-1:0]   rx_data
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;

    always_comb begin
      byte_d = upd_data[gi*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (upd_valid[gi]) begin
        byte_q <= byte_d;
      end
    end

    assign rx_data[gi*DATA_W +: DATA_W] = byte_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid[gi] |=> $stable(rx_data[gi*DATA_W +: DATA_W])); // R2
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid[gi] |=> rx_data[gi*DATA_W +: DATA_W] == $past(upd_data[gi*DATA_W +: DATA_W])); // R2
  end
endmodule

// File: rtl/rxd_event_qual.sv
module rxd_event_qual
  import rxd_irq_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  cond_e                        cond,
  input  logic [NUM_REGS-1:0]          upd_valid,
  input  logic [NUM_REGS*DATA_W-1:0]   upd_data,
  output logic                         hw_evt
);
  localparam int LAST_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0] lane_nz;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_nz
    assign lane_nz[gi] = upd_valid[gi] & (|upd_data[gi*DATA_W +: DATA_W]);
  end

  always_comb begin
    unique case (cond)
      COND_ANY:     hw_evt = |upd_valid;
      COND_NONZERO: hw_evt = |lane_nz;
      COND_LAST:    hw_evt = upd_valid[LAST_IDX];
      default:      hw_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxd_status_flag.sv
module rxd_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_evt,
  input  logic sw_set,
  input  logic sw_clr,
  output logic status_flag,
  output logic irq_pulse
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;
  logic flag_en;

  always_comb begin
    flag_en = hw_evt | sw_set | sw_clr;
    flag_d  = hw_evt | sw_set;
    irq_d   = hw_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign status_flag = flag_q;
  assign irq_pulse   = irq_q;

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> status_flag); // R5
  AST_SWSET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !hw_evt) |=> !irq_pulse && status_flag); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !sw_set && !hw_evt) |=> !status_flag); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flag && !sw_clr) |=> status_flag); // R9
  AST_HW_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> status_flag && irq_pulse); // R10
endmodule

// File: rtl/rxd_irq_ctrl.sv
module rxd_irq_ctrl
  import rxd_irq_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_mode,
  output logic [1:0]                   mode_o,
  input  logic [NUM_REGS-1:0]          upd_valid,
  input  logic [NUM_REGS*DATA_W-1:0]   upd_data,
  output logic [NUM_REGS*DATA_W-1:0]   rx_data,
  input  logic                         sw_set,
  input  logic                         sw_clr,
  output logic                         status_flag,
  output logic                         irq_pulse
);
  localparam int LAST_IDX = NUM_REGS - 1;

  cond_e cond_q, cond_d;
  logic  hw_evt;

  always_comb begin
    cond_d = cond_e'(cfg_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= COND_OFF;
    end else if (cfg_we) begin
      cond_q <= cond_d;
    end
  end

  assign mode_o = cond_q;

  rxd_data_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_data  (upd_data),
    .rx_data   (rx_data)
  );

  rxd_event_qual #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_qual (
    .cond      (cond_q),
    .upd_valid (upd_valid),
    .upd_data  (upd_data),
    .hw_evt    (hw_evt)
  );

  rxd_status_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_evt      (hw_evt),
    .sw_set      (sw_set),
    .sw_clr      (sw_clr),
    .status_flag (status_flag),
    .irq_pulse   (irq_pulse)
  );

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> mode_o == $past(cfg_mode)); // R3
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |=> !irq_pulse); // R4
  AST_LAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !upd_valid[LAST_IDX]) |=> !irq_pulse); // R7
endmodule

// File: tb/rxd_irq_ctrl_tb.sv
module rxd_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int DW = 8;
  localparam int WATCHDOG_CYC = 150000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [1:0]      cfg_mode;
  logic [1:0]      mode_o;
  logic [NR-1:0]   upd_valid;
  logic [NR*DW-1:0] upd_data;
  logic [NR*DW-1:0] rx_data;
  logic            sw_set, sw_clr;
  logic            status_flag, irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxd_irq_ctrl #(.NUM_REGS(NR), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_o(mode_o),
    .upd_valid(upd_valid), .upd_data(upd_data), .rx_data(rx_data),
    .sw_set(sw_set), .sw_clr(sw_clr), .status_flag(status_flag), .irq_pulse(irq_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] lane_val(input int i);
    return DW'((i + 1) * 17);
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++) chk(req, 32'(rx_data[i*DW +: DW]), 32'(model[i]));
  endtask

  task automatic write_mode(input logic [1:0] m);
    cfg_we = 1'b1; cfg_mode = m;
    tick();
    cfg_we = 1'b0;
    chk("R3 mode load", 32'(mode_o), 32'(m));
  endtask

  task automatic clear_flag();
    sw_clr = 1'b1;
    tick();
    sw_clr = 1'b0;
    chk("R9 clear", 32'(status_flag), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = '0; upd_valid = '0; upd_data = '0;
    sw_set = 1'b0; sw_clr = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    // put nonzero bytes on the bus during reset; nothing must load
    upd_valid = '1; upd_data = '1;
    repeat (3) @(posedge clk);
    #1;
    upd_valid = '0; upd_data = '0;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mode", 32'(mode_o), 32'd0);
    chk("R1 flag", 32'(status_flag), 32'd0);
    chk("R1 irq", 32'(irq_pulse), 32'd0);
    check_regs("R1 data");
    tick();

    // Full sweep: condition x strobe mask x zero/nonzero lane pattern
    for (int m = 0; m < 4; m++) begin
      write_mode(2'(m));
      for (int k = 0; k < (1 << NR); k++) begin
        for (int p = 0; p < (1 << NR); p++) begin
          logic exp_evt;
          logic [NR-1:0] nzmask;
          clear_flag();
          nzmask = 4'(k) & 4'(p);
          case (m)
            0: exp_evt = 1'b0;
            1: exp_evt = |4'(k);
            2: exp_evt = |nzmask;
            default: exp_evt = k[NR-1];
          endcase
          upd_valid = 4'(k);
          for (int i = 0; i < NR; i++) begin
            upd_data[i*DW +: DW] = p[i] ? lane_val(i) : '0;
            if (k[i]) model[i] = p[i] ? lane_val(i) : '0;
          end
          tick();
          upd_valid = '0; upd_data = '0;
          case (m)
            0: chk("R4 off irq", 32'(irq_pulse), 32'(exp_evt));
            1: chk("R5 any irq", 32'(irq_pulse), 32'(exp_evt));
            2: chk("R6 nonzero irq", 32'(irq_pulse), 32'(exp_evt));
            default: chk("R7 last irq", 32'(irq_pulse), 32'(exp_evt));
          endcase
          chk("R5 flag follows event", 32'(status_flag), 32'(exp_evt));
          check_regs("R2 data");
          tick();
          chk("R8 pulse single cycle", 32'(irq_pulse), 32'd0);
          chk("R9 flag sticky", 32'(status_flag), 32'(exp_evt));
        end
      end
    end

    // R6: old register value nonzero, new byte zero -> no event
    write_mode(2'b10);
    clear_flag();
    upd_valid = 4'b0001; upd_data = 32'h0000_00A5;
    tick();
    upd_valid = 4'b0001; upd_data = 32'h0000_0000;
    tick();
    upd_valid = '0;
    chk("R6 zero over nonzero", 32'(irq_pulse), 32'd0);
    chk("R2 zero loaded", 32'(rx_data[7:0]), 32'd0);

    // R3: mode write together with update is judged under old mode
    write_mode(2'b00);
    clear_flag();
    cfg_we = 1'b1; cfg_mode = 2'b01; upd_valid = 4'b1000; upd_data = 32'h5A00_0000;
    tick();
    cfg_we = 1'b0; upd_valid = '0;
    chk("R3 old mode governs", 32'(irq_pulse), 32'd0);
    upd_valid = 4'b0010; upd_data = 32'h0000_3300;
    tick();
    upd_valid = '0;
    chk("R3 new mode applies", 32'(irq_pulse), 32'd1);

    // R9: software set, no pulse; zero strobes hold
    clear_flag();
    sw_set = 1'b1;
    tick();
    sw_set = 1'b0;
    chk("R9 sw set flag", 32'(status_flag), 32'd1);
    chk("R9 sw set no irq", 32'(irq_pulse), 32'd0);
    tick();
    chk("R9 zero writes hold 1", 32'(status_flag), 32'd1);
    clear_flag();
    tick();
    chk("R9 zero writes hold 0", 32'(status_flag), 32'd0);

    // R10: hardware event with clear
    upd_valid = 4'b0100; upd_data = 32'h0077_0000; sw_clr = 1'b1;
    tick();
    upd_valid = '0; sw_clr = 1'b0;
    chk("R10 hw beats clear flag", 32'(status_flag), 32'd1);
    chk("R10 hw beats clear irq", 32'(irq_pulse), 32'd1);
    // R10: set with clear
    clear_flag();
    sw_set = 1'b1; sw_clr = 1'b1;
    tick();
    sw_set = 1'b0; sw_clr = 1'b0;
    chk("R10 set with clear", 32'(status_flag), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule